// File: doc/BRIEF.md
# Reconfigurable Bank-to-Cluster Multiplexer Network

This block sits between the memory banks and the SIMD compute clusters of a data-parallel processor. It has one bank per cluster, and both are arranged in groups of four. When the workload offers less data parallelism, software can shrink the set of working clusters. The network then folds the words of every bank in a group onto the clusters that stay powered, one after another over successive cycles, so no bank's data is left behind. It also drops the power-gate enables of the clusters it no longer feeds.

A transfer begins with a start strobe while the block is idle. In the same cycle the block latches the requested mode and takes one word, plus its valid flag, from every bank. In the next cycle the power-gate enables for the new mode are in place. The captured words then leave on the cluster outputs over one, two or four cycles, depending on the mode. Every output word carries the global index of the bank it came from.

Top module: `bank_cluster_mux_net`

## Requirements
- R1: `mode_i` is decoded as 0 = all clusters fed, 1 = two of four fed, 2 = one of four fed, 3 = all gated off. It is sampled only at an accepted start; changing it at any other time has no effect on gates or outputs.
- R2: In mode 0, every cluster i receives the word of bank i in the single output cycle of the transfer.
- R3: In mode 1, within each group of four (local indices 0..3), local cluster 0 receives local bank 0 and then bank 1 on consecutive cycles, local cluster 2 receives bank 2 and then bank 3, and local clusters 1 and 3 never assert valid.
- R4: In mode 2, local cluster 0 of each group receives local banks 0, 1, 2, 3 in that order on four consecutive cycles; the other three clusters never assert valid.
- R5: In mode 3, no cluster output asserts valid, and busy stays high for exactly one cycle.
- R6: `cl_gate_o` bit i is high exactly when cluster i is fed in the latched mode (mode 0: all; mode 1: local 0 and 2; mode 2: local 0; mode 3: none). The enables hold from the cycle after an accepted start until the next accepted start, including after the transfer ends.
- R7: A start is accepted at a clock edge where `start_i` is high and `busy_o` is low. `busy_o` is then high for P+1 cycles (P = 1, 2, 4, 0 for modes 0..3). The first output word appears two cycles after the start edge, so every enable is high at least one cycle before its cluster's first valid word. No valid word appears while busy is low.
- R8: Bank words and valids are captured at the accepted start; later bank input changes do not affect the transfer. An output word's valid equals the captured valid of its source bank, and its tag is the global source bank index. An output with valid low carries zero data and a zero tag.
- R9: A start raised while busy is ignored: the ongoing sequence, the gates and the captured data are unchanged.
- R10: After reset, busy is low, all valids are low and all power-gate enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one transfer |
| mode_i | input | 2 | Requested cluster mode, sampled at an accepted start |
| bank_data_i | input | 4*NUM_GROUPS*DATA_W | Read word of each bank, bank 0 in the low slice |
| bank_valid_i | input | 4*NUM_GROUPS | Read-word valid of each bank |
| cl_data_o | output | 4*NUM_GROUPS*DATA_W | Word delivered to each cluster |
| cl_valid_o | output | 4*NUM_GROUPS | Valid of each cluster word |
| cl_tag_o | output | 4*NUM_GROUPS*TAG_W | Source bank index of each cluster word |
| cl_gate_o | output | 4*NUM_GROUPS | Power-gate enable per cluster, high = powered |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench builds the block with two groups (eight banks and clusters) and 16-bit words, so TAG_W is 3. This exposes whether folding and tagging stay inside each group and whether the second group's tags carry the group offset. With only two groups the run stays short, yet it still covers every mode with full and partial bank-valid masks and the one-, two- and four-cycle sequences. It also covers restarts attempted mid-transfer and bank inputs that change after capture.

// File: rtl/bcmn_pkg.sv
package bcmn_pkg;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'd0,
        MODE_HALF    = 2'd1,
        MODE_QUARTER = 2'd2,
        MODE_OFF     = 2'd3
    } net_mode_e;

    localparam int unsigned GROUP_SIZE = 4;

    // Number of output cycles one transfer needs in a given mode.
    function automatic logic [2:0] phase_count(net_mode_e m);
        case (m)
            MODE_FULL:    return 3'd1;
            MODE_HALF:    return 3'd2;
            MODE_QUARTER: return 3'd4;
            default:      return 3'd0;
        endcase
    endfunction

    // Clusters of one group that stay powered in a given mode.
    function automatic logic [3:0] gate_mask(net_mode_e m);
        case (m)
            MODE_FULL:    return 4'b1111;
            MODE_HALF:    return 4'b0101;
            MODE_QUARTER: return 4'b0001;
            default:      return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/bcmn_seq.sv
module bcmn_seq
    import bcmn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic [1:0] mode_i,
    output logic      load_o,
    output logic      emit_o,
    output logic [1:0] phase_o,
    output net_mode_e mode_o,
    output logic      busy_o
);

    typedef struct packed {
        logic      busy;
        logic [2:0] cnt;
        net_mode_e mode;
    } seq_state_t;

    seq_state_t seq_d, seq_q;
    logic       load_w;
    logic       emit_w;

    always_comb begin
        load_w = start_i && !seq_q.busy;
        emit_w = seq_q.busy && (seq_q.cnt != phase_count(seq_q.mode));
        seq_d  = seq_q;
        if (load_w) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = 3'd0;
            seq_d.mode = net_mode_e'(mode_i);
        end else if (seq_q.busy) begin
            if (emit_w) begin
                seq_d.cnt = seq_q.cnt + 3'd1;
            end else begin
                seq_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{busy: 1'b0, cnt: 3'd0, mode: MODE_OFF};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign load_o  = load_w;
    assign emit_o  = emit_w;
    assign phase_o = seq_q.cnt[1:0];
    assign mode_o  = seq_q.mode;
    assign busy_o  = seq_q.busy;

endmodule

// File: rtl/bcmn_group_gate.sv
module bcmn_group_gate
    import bcmn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] mode_i,
    output logic [3:0] gate_o
);

    logic [3:0] gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (load_i) begin
            gate_d = gate_mask(net_mode_e'(mode_i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 4'b0000;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gate_o = gate_q;

endmodule

// File: rtl/bcmn_group_route.sv
module bcmn_group_route
    import bcmn_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned TAG_W     = 3,
    parameter int unsigned GROUP_IDX = 0
) (
    input  net_mode_e                    mode_i,
    input  logic [1:0]                   phase_i,
    input  logic                         emit_i,
    input  logic [GROUP_SIZE*DATA_W-1:0] bank_data_i,
    input  logic [GROUP_SIZE-1:0]        bank_valid_i,
    output logic [GROUP_SIZE*DATA_W-1:0] cl_data_o,
    output logic [GROUP_SIZE-1:0]        cl_valid_o,
    output logic [GROUP_SIZE*TAG_W-1:0]  cl_tag_o
);

    localparam logic [TAG_W-1:0] TAG_BASE = TAG_W'(GROUP_IDX * GROUP_SIZE);

    logic [1:0] src;
    logic       served;

    always_comb begin
        cl_data_o  = '0;
        cl_valid_o = '0;
        cl_tag_o   = '0;
        src        = 2'd0;
        served     = 1'b0;
        for (int c = 0; c < GROUP_SIZE; c++) begin
            served = 1'b0;
            src    = 2'(c);
            case (mode_i)
                MODE_FULL: begin
                    served = 1'b1;
                    src    = 2'(c);
                end
                MODE_HALF: begin
                    if (c == 0 || c == 2) begin
                        served = 1'b1;
                        src    = 2'(c) + {1'b0, phase_i[0]};
                    end
                end
                MODE_QUARTER: begin
                    if (c == 0) begin
                        served = 1'b1;
                        src    = phase_i;
                    end
                end
                default: served = 1'b0;
            endcase
            if (emit_i && served && bank_valid_i[src]) begin
                cl_valid_o[c]                 = 1'b1;
                cl_data_o[c*DATA_W +: DATA_W] = bank_data_i[src*DATA_W +: DATA_W];
                cl_tag_o[c*TAG_W +: TAG_W]    = TAG_BASE + TAG_W'(src);
            end
        end
    end

endmodule

// File: rtl/bank_cluster_mux_net.sv
module bank_cluster_mux_net
    import bcmn_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 2,
    parameter int unsigned DATA_W     = 16,
    localparam int unsigned N_CL      = GROUP_SIZE * NUM_GROUPS,
    localparam int unsigned TAG_W     = (N_CL > 1) ? $clog2(N_CL) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [1:0]              mode_i,
    input  logic [N_CL*DATA_W-1:0]  bank_data_i,
    input  logic [N_CL-1:0]         bank_valid_i,
    output logic [N_CL*DATA_W-1:0]  cl_data_o,
    output logic [N_CL-1:0]         cl_valid_o,
    output logic [N_CL*TAG_W-1:0]   cl_tag_o,
    output logic [N_CL-1:0]         cl_gate_o,
    output logic                    busy_o
);

    localparam int unsigned GRP_DW = GROUP_SIZE * DATA_W;
    localparam int unsigned GRP_TW = GROUP_SIZE * TAG_W;

    typedef struct packed {
        logic [N_CL*DATA_W-1:0] stage_data;
        logic [N_CL-1:0]        stage_valid;
        logic [N_CL*DATA_W-1:0] out_data;
        logic [N_CL-1:0]        out_valid;
        logic [N_CL*TAG_W-1:0]  out_tag;
    } net_state_t;

    net_state_t net_d, net_q;

    logic       load_w;
    logic       emit_w;
    logic [1:0] phase_w;
    net_mode_e  mode_w;

    logic [N_CL*DATA_W-1:0] route_data;
    logic [N_CL-1:0]        route_valid;
    logic [N_CL*TAG_W-1:0]  route_tag;

    bcmn_seq seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (mode_i),
        .load_o  (load_w),
        .emit_o  (emit_w),
        .phase_o (phase_w),
        .mode_o  (mode_w),
        .busy_o  (busy_o)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        bcmn_group_route #(
            .DATA_W    (DATA_W),
            .TAG_W     (TAG_W),
            .GROUP_IDX (g)
        ) route_i (
            .mode_i       (mode_w),
            .phase_i      (phase_w),
            .emit_i       (emit_w),
            .bank_data_i  (net_q.stage_data[g*GRP_DW +: GRP_DW]),
            .bank_valid_i (net_q.stage_valid[g*GROUP_SIZE +: GROUP_SIZE]),
            .cl_data_o    (route_data[g*GRP_DW +: GRP_DW]),
            .cl_valid_o   (route_valid[g*GROUP_SIZE +: GROUP_SIZE]),
            .cl_tag_o     (route_tag[g*GRP_TW +: GRP_TW])
        );

        bcmn_group_gate gate_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_w),
            .mode_i (mode_i),
            .gate_o (cl_gate_o[g*GROUP_SIZE +: GROUP_SIZE])
        );
    end

    always_comb begin
        net_d = net_q;
        if (load_w) begin
            net_d.stage_data  = bank_data_i;
            net_d.stage_valid = bank_valid_i;
        end
        net_d.out_data  = route_data;
        net_d.out_valid = route_valid;
        net_d.out_tag   = route_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            net_q <= '0;
        end else begin
            net_q <= net_d;
        end
    end

    assign cl_data_o  = net_q.out_data;
    assign cl_valid_o = net_q.out_valid;
    assign cl_tag_o   = net_q.out_tag;

endmodule

// File: rtl/bcmn_checker.sv
module bcmn_checker #(
    parameter int unsigned NUM_GROUPS = 2,
    localparam int unsigned N_CL      = 4 * NUM_GROUPS,
    localparam int unsigned TAG_W     = (N_CL > 1) ? $clog2(N_CL) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_CL-1:0]        cl_valid_o,
    input logic [N_CL*TAG_W-1:0]  cl_tag_o,
    input logic [N_CL-1:0]        cl_gate_o,
    input logic                   busy_o
);

    for (genvar i = 0; i < N_CL; i++) begin : g_cl
        AST_GATE_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            cl_valid_o[i] |-> $past(cl_gate_o[i])); // R7

        AST_DARK_CLUSTER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !cl_gate_o[i] |-> !cl_valid_o[i]); // R6

        AST_TAG_IN_OWN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
            cl_valid_o[i] |-> (int'(cl_tag_o[i*TAG_W +: TAG_W]) / 4 == i / 4)); // R8
    end

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cl_valid_o == '0)); // R7

    AST_GATES_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cl_gate_o)); // R9

endmodule

bind bank_cluster_mux_net bcmn_checker #(
    .NUM_GROUPS (NUM_GROUPS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cl_valid_o (cl_valid_o),
    .cl_tag_o   (cl_tag_o),
    .cl_gate_o  (cl_gate_o),
    .busy_o     (busy_o)
);

// File: tb/bank_cluster_mux_net_tb_top.sv
module bank_cluster_mux_net_tb_top;

    localparam int NG  = 2;
    localparam int DW  = 16;
    localparam int N   = 4 * NG;
    localparam int TW  = 3;

    // {mode, bank valid mask, seed}
    localparam logic [17:0] VECS [0:6] = '{
        {2'd0, 8'hFF, 8'h3C},
        {2'd1, 8'hFF, 8'h51},
        {2'd2, 8'hFF, 8'h7E},
        {2'd3, 8'hFF, 8'h90},
        {2'd1, 8'hA6, 8'h12},
        {2'd2, 8'h5B, 8'hC4},
        {2'd0, 8'h69, 8'hE7}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [1:0]         mode_i = 2'd0;
    logic [N*DW-1:0]    bank_data_i = '0;
    logic [N-1:0]       bank_valid_i = '0;
    logic [N*DW-1:0]    cl_data_o;
    logic [N-1:0]       cl_valid_o;
    logic [N*TW-1:0]    cl_tag_o;
    logic [N-1:0]       cl_gate_o;
    logic               busy_o;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    bank_cluster_mux_net #(.NUM_GROUPS(NG), .DATA_W(DW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .bank_data_i  (bank_data_i),
        .bank_valid_i (bank_valid_i),
        .cl_data_o    (cl_data_o),
        .cl_valid_o   (cl_valid_o),
        .cl_tag_o     (cl_tag_o),
        .cl_gate_o    (cl_gate_o),
        .busy_o       (busy_o)
    );

    function automatic logic [15:0] bank_word(logic [7:0] seed, int b);
        return {seed + 8'(b * 37), 8'hA0 | 8'(b)};
    endfunction

    function automatic int n_phases(logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 0;
    endfunction

    function automatic logic [N-1:0] exp_gates(logic [1:0] m);
        logic [N-1:0] r = '0;
        for (int c = 0; c < N; c++) begin
            case (m)
                2'd0: r[c] = 1'b1;
                2'd1: r[c] = (c % 4 == 0) || (c % 4 == 2);
                2'd2: r[c] = (c % 4 == 0);
                default: r[c] = 1'b0;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected outputs for output cycle k, mapping each bank to its destination.
    task automatic check_phase(input logic [1:0] m, input logic [7:0] vm,
                               input logic [7:0] seed, input int k, input string req);
        logic [N*DW-1:0] ed = '0;
        logic [N-1:0]    ev = '0;
        logic [N*TW-1:0] et = '0;
        for (int b = 0; b < N; b++) begin
            int g = b / 4;
            int l = b % 4;
            int cl = -1;
            int ph = 0;
            case (m)
                2'd0: begin cl = b; ph = 0; end
                2'd1: begin cl = 4 * g + (l / 2) * 2; ph = l % 2; end
                2'd2: begin cl = 4 * g; ph = l; end
                default: cl = -1;
            endcase
            if (cl >= 0 && ph == k && vm[b]) begin
                ev[cl]          = 1'b1;
                ed[cl*DW +: DW] = bank_word(seed, b);
                et[cl*TW +: TW] = TW'(b);
            end
        end
        check(req, $sformatf("valid cycle %0d", k), 128'(cl_valid_o), 128'(ev));
        check(req, $sformatf("data cycle %0d", k), 128'(cl_data_o), 128'(ed));
        check("R8", $sformatf("tag cycle %0d", k), 128'(cl_tag_o), 128'(et));
        check("R7", $sformatf("busy cycle %0d", k), 128'(busy_o), 128'(1));
    endtask

    task automatic run_vec(input logic [1:0] m, input logic [7:0] vm,
                           input logic [7:0] seed, input bit poke_busy);
        string req;
        int    p = n_phases(m);
        req = (m == 2'd0) ? "R2" : (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R5";
        for (int b = 0; b < N; b++) bank_data_i[b*DW +: DW] = bank_word(seed, b);
        bank_valid_i = vm;
        mode_i  = m;
        start_i = 1'b1;
        @(negedge clk);
        // After the start edge: gates set, busy high, nothing valid yet.
        check("R6", "gates after start", 128'(cl_gate_o), 128'(exp_gates(m)));
        check("R7", "busy after start", 128'(busy_o), 128'(1));
        check("R7", "no data in gate cycle", 128'(cl_valid_o), 128'(0));
        start_i      = 1'b0;
        bank_data_i  = ~bank_data_i;   // R8: capture must hold
        bank_valid_i = ~vm;
        mode_i       = ~m;
        for (int k = 0; k < p; k++) begin
            if (poke_busy && k == 0) begin
                start_i = 1'b1;        // R9: should be ignored
            end
            @(negedge clk);
            start_i = 1'b0;
            check_phase(m, vm, seed, k, req);
            check("R9", $sformatf("gates held cycle %0d", k), 128'(cl_gate_o), 128'(exp_gates(m)));
        end
        @(negedge clk);
        check("R7", "busy low after transfer", 128'(busy_o), 128'(0));
        check(req, "no valid after transfer", 128'(cl_valid_o), 128'(0));
        check("R6", "gates kept after transfer", 128'(cl_gate_o), 128'(exp_gates(m)));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "busy in reset", 128'(busy_o), 128'(0));
        check("R10", "valid in reset", 128'(cl_valid_o), 128'(0));
        check("R10", "gates in reset", 128'(cl_gate_o), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "gates after reset", 128'(cl_gate_o), 128'(0));

        foreach (VECS[i]) begin
            run_vec(VECS[i][17:16], VECS[i][15:8], VECS[i][7:0], 1'b0);
        end

        // R9: restart attempts during busy in quarter and half modes
        run_vec(2'd2, 8'hFF, 8'h2D, 1'b1);
        run_vec(2'd1, 8'h3F, 8'hB8, 1'b1);

        // R1: mode changes without a start leave gates and outputs alone
        mode_i = 2'd0;
        repeat (3) @(negedge clk);
        check("R1", "gates without start", 128'(cl_gate_o), 128'(exp_gates(2'd1)));
        check("R1", "valid without start", 128'(cl_valid_o), 128'(0));
        check("R1", "busy without start", 128'(busy_o), 128'(0));

        // R5 then R6: gate everything off, then back on in full mode
        run_vec(2'd3, 8'h00, 8'h00, 1'b0);
        run_vec(2'd0, 8'hFF, 8'h44, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule